// File: doc/BRIEF.md
# Stream DMA Run/Reset Control Register

This block is the per-stream control word that sits between a software register bus and one stream DMA engine. Software writes a 32-bit word to set a 4-bit stream tag, to start or stop the engine, and to put the stream into reset or take it out of reset. The run and reset bits do not simply return the last value written. They read back the engine's real status. After a stop request the run bit keeps reading 1 until the engine reports that it has halted. After a reset request the reset bit reads 1 only once the reset sequence has finished, and it keeps reading 1 after a release request until the stream reports that it is ready.

A single state machine tracks the stream through six named states. `ST_IDLE` means stopped and out of reset. `ST_RUN` means the engine is enabled. `ST_STOP` means a stop has been requested and is not yet acknowledged. `ST_RST_ENTER` means the reset sequence is in progress. `ST_RST_HOLD` means the stream is held in reset. `ST_RST_EXIT` means a release has been requested and is not yet acknowledged.

The named transitions are:
- `START`: `ST_IDLE` to `ST_RUN` on a write with the run bit set and the reset bit clear.
- `HALT`: `ST_RUN` to `ST_STOP` on a write with the run bit clear.
- `STOPPED`: `ST_STOP` to `ST_IDLE` when `eng_stopped` is high.
- `RESET`: `ST_IDLE` to `ST_RST_ENTER` on a write with the reset bit set.
- `RESET_DONE`: `ST_RST_ENTER` to `ST_RST_HOLD` when `rst_done` is high.
- `RELEASE`: `ST_RST_HOLD` to `ST_RST_EXIT` on a write with the reset bit clear.
- `READY`: `ST_RST_EXIT` to `ST_IDLE` when `eng_ready` is high.

The engine receives these outputs:
- A run enable.
- A gated go signal, which is held off while the stream-sync input is high.
- A reset request.
- A one-cycle cadence reset when an output stream starts.

A sticky error flag records any attempt to reset the stream while it still reads as running.

Top module: `stream_ctl_reg`

## Requirements
- R1: The read word places the tag at bits 23:20, the run status at bit 1 and the reset status at bit 0. Bits 31:24 and 19:2 always read 0, and writing them has no effect.
- R2: Out of reset, a write stores wr_data[23:20] as the tag. The tag appears on `tag_out` and in the read word from the cycle after the write edge.
- R3: `run_en` is 1 only in `ST_RUN`. `dma_go` is 1 only when `run_en` is 1 and `stream_sync` is 0.
- R4: A `START` write while `is_output` is 1 makes `cad_rst` high for exactly the one cycle after the write edge. A start with `is_output` at 0 gives no pulse.
- R5: After a `HALT` write, `run_en` drops in the next cycle, but the run bit reads 1 until an edge at which `eng_stopped` is 1. It reads 0 after that edge.
- R6: A `RESET` write from `ST_IDLE` raises `srst_req` and clears the tag. The reset bit reads 0 until an edge with `rst_done` at 1, and reads 1 after it. The run bit in that write is ignored.
- R7: A `RELEASE` write drops `srst_req` in the next cycle. The reset bit keeps reading 1 until an edge with `eng_ready` at 1, and reads 0 after it.
- R8: A write with bit 0 set while the run bit reads 1 does not enter reset, and it sets `seq_err`. `seq_err` stays 1 until `rst_n` is asserted. In that write, the tag and run fields still act as in any other write.
- R9: From `ST_RST_ENTER` through `ST_RST_EXIT`, tag and run writes are discarded, and the tag reads 0 on `tag_out` and in the read word.
- R10: A write with bit 1 set during `ST_STOP` does not restart the engine. The tag field of that write is still stored.
- R11: After `rst_n` the read word, `run_en`, `dma_go`, `srst_req`, `cad_rst`, `seq_err` and `tag_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word being written |
| rd_data | output | 32 | Read-back control word with live status |
| is_output | input | 1 | High when the stream is an output stream |
| stream_sync | input | 1 | Stream-sync hold: while high, it blocks data movement |
| eng_stopped | input | 1 | Engine reports that it has halted |
| rst_done | input | 1 | Engine reports that the reset sequence is complete |
| eng_ready | input | 1 | Engine reports that it is ready after release |
| run_en | output | 1 | Run enable to the engine |
| dma_go | output | 1 | Run enable gated by stream_sync |
| srst_req | output | 1 | Reset request to the stream hardware |
| cad_rst | output | 1 | One-cycle cadence generator reset |
| tag_out | output | 4 | Current stream tag |
| seq_err | output | 1 | Sticky flag for a reset attempted while running |

## Verification
Every write and every acknowledgement takes effect at the clock edge where it is sampled. The read word, `run_en`, `srst_req`, `tag_out` and `seq_err` show the new value in the cycle right after that edge. `cad_rst` is high only in that same following cycle. `dma_go` follows `stream_sync` within the same cycle. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It compares all outputs 1 ns after the rising edge, so each result is checked in the first cycle it is due. The acknowledgement inputs are raised after a random 0 to 3 cycle wait in each waiting state. This means the held readings in `ST_STOP`, `ST_RST_ENTER` and `ST_RST_EXIT` are observed over several cycles.

// File: rtl/stream_ctl_pkg.sv
package stream_ctl_pkg;
    localparam int DATA_W   = 32;
    localparam int TAG_W    = 4;
    localparam int TAG_LSB  = 20;
    localparam int RUN_BIT  = 1;
    localparam int SRST_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RUN       = 3'd1,
        ST_STOP      = 3'd2,
        ST_RST_ENTER = 3'd3,
        ST_RST_HOLD  = 3'd4,
        ST_RST_EXIT  = 3'd5
    } sc_state_e;
endpackage

// File: rtl/stream_ctl_fsm.sv
module stream_ctl_fsm
    import stream_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_run,
    input  logic      wr_srst,
    input  logic      is_output,
    input  logic      eng_stopped,
    input  logic      rst_done,
    input  logic      eng_ready,
    output sc_state_e state,
    output logic      run_en,
    output logic      srst_req,
    output logic      start_out,
    output logic      tag_we,
    output logic      tag_clr,
    output logic      err_set
);
    sc_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_en && wr_srst)     nxt = ST_RST_ENTER;   // RESET
                else if (wr_en && wr_run) nxt = ST_RUN;         // START
            end
            ST_RUN: begin
                if (wr_en && !wr_run)     nxt = ST_STOP;        // HALT
            end
            ST_STOP: begin
                if (eng_stopped)          nxt = ST_IDLE;        // STOPPED
            end
            ST_RST_ENTER: begin
                if (rst_done)             nxt = ST_RST_HOLD;    // RESET_DONE
            end
            ST_RST_HOLD: begin
                if (wr_en && !wr_srst)    nxt = ST_RST_EXIT;    // RELEASE
            end
            ST_RST_EXIT: begin
                if (eng_ready)            nxt = ST_IDLE;        // READY
            end
            default:                      nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        run_en    = 1'b0;
        srst_req  = 1'b0;
        start_out = 1'b0;
        tag_we    = 1'b0;
        tag_clr   = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tag_clr   = wr_en && wr_srst;
                tag_we    = wr_en && !wr_srst;
                start_out = wr_en && !wr_srst && wr_run && is_output;
            end
            ST_RUN: begin
                run_en  = 1'b1;
                tag_we  = wr_en;
                err_set = wr_en && wr_srst;
            end
            ST_STOP: begin
                tag_we  = wr_en;
                err_set = wr_en && wr_srst;
            end
            ST_RST_ENTER,
            ST_RST_HOLD: srst_req = 1'b1;
            ST_RST_EXIT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/stream_ctl_fields.sv
module stream_ctl_fields #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_we,
    input  logic             tag_clr,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             start_out,
    input  logic             err_set,
    output logic [TAG_W-1:0] tag_q,
    output logic             cad_q,
    output logic             err_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tag_q <= '0;
        else if (tag_clr) tag_q <= '0;
        else if (tag_we)  tag_q <= tag_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cad_q <= 1'b0;
        else        cad_q <= start_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end
endmodule

// File: rtl/stream_ctl_readback.sv
module stream_ctl_readback
    import stream_ctl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int T_LSB = 20,
    parameter int R_BIT = 1,
    parameter int S_BIT = 0
) (
    input  sc_state_e     state,
    input  logic [TW-1:0] tag_q,
    output logic [TW-1:0] tag_vis,
    output logic [DW-1:0] rd_word
);
    logic run_vis, srst_vis, in_rst;

    always_comb begin
        run_vis  = (state == ST_RUN) || (state == ST_STOP);
        srst_vis = (state == ST_RST_HOLD) || (state == ST_RST_EXIT);
        in_rst   = (state == ST_RST_ENTER) || srst_vis;
        tag_vis  = in_rst ? '0 : tag_q;
        rd_word  = '0;
        rd_word[T_LSB +: TW] = tag_vis;
        rd_word[R_BIT]       = run_vis;
        rd_word[S_BIT]       = srst_vis;
    end
endmodule

// File: rtl/stream_ctl_reg.sv
module stream_ctl_reg
    import stream_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              is_output,
    input  logic              stream_sync,
    input  logic              eng_stopped,
    input  logic              rst_done,
    input  logic              eng_ready,
    output logic              run_en,
    output logic              dma_go,
    output logic              srst_req,
    output logic              cad_rst,
    output logic [TAG_W-1:0]  tag_out,
    output logic              seq_err
);
    sc_state_e        state;
    logic             start_out, tag_we, tag_clr, err_set;
    logic [TAG_W-1:0] tag_q;

    stream_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_run      (wr_data[RUN_BIT]),
        .wr_srst     (wr_data[SRST_BIT]),
        .is_output   (is_output),
        .eng_stopped (eng_stopped),
        .rst_done    (rst_done),
        .eng_ready   (eng_ready),
        .state       (state),
        .run_en      (run_en),
        .srst_req    (srst_req),
        .start_out   (start_out),
        .tag_we      (tag_we),
        .tag_clr     (tag_clr),
        .err_set     (err_set)
    );

    stream_ctl_fields #(.TAG_W(TAG_W)) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_we    (tag_we),
        .tag_clr   (tag_clr),
        .tag_in    (wr_data[TAG_LSB +: TAG_W]),
        .start_out (start_out),
        .err_set   (err_set),
        .tag_q     (tag_q),
        .cad_q     (cad_rst),
        .err_q     (seq_err)
    );

    stream_ctl_readback #(
        .DW(DATA_W), .TW(TAG_W), .T_LSB(TAG_LSB), .R_BIT(RUN_BIT), .S_BIT(SRST_BIT)
    ) u_rb (
        .state   (state),
        .tag_q   (tag_q),
        .tag_vis (tag_out),
        .rd_word (rd_data)
    );

    assign dma_go = run_en && !stream_sync;
endmodule

// File: rtl/stream_ctl_checker.sv
module stream_ctl_checker #(
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int T_LSB = 20,
    parameter int R_BIT = 1,
    parameter int S_BIT = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rd_data,
    input logic          run_en,
    input logic          srst_req,
    input logic          cad_rst,
    input logic          seq_err,
    input logic          eng_stopped,
    input logic          eng_ready,
    input logic [TW-1:0] tag_out
);
    assert_cad_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cad_rst |=> !cad_rst);

    assert_run_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[R_BIT] && !run_en && !eng_stopped) |=> rd_data[R_BIT]);

    assert_srst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[S_BIT] && !srst_req && !eng_ready) |=> rd_data[S_BIT]);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    assert_no_run_in_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |-> (!run_en && tag_out == '0 && rd_data[T_LSB +: TW] == '0));
endmodule

bind stream_ctl_reg stream_ctl_checker #(
    .DW(32), .TW(4), .T_LSB(20), .R_BIT(1), .S_BIT(0)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .run_en      (run_en),
    .srst_req    (srst_req),
    .cad_rst     (cad_rst),
    .seq_err     (seq_err),
    .eng_stopped (eng_stopped),
    .eng_ready   (eng_ready),
    .tag_out     (tag_out)
);

// File: tb/test_stream_ctl_reg.sv
`timescale 1ns/1ps
module test_stream_ctl_reg;
    localparam int M_IDLE = 0, M_RUN = 1, M_STOP = 2, M_ENT = 3, M_HOLD = 4, M_EXIT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        is_output = 1'b0, stream_sync = 1'b0;
    logic        eng_stopped = 1'b0, rst_done = 1'b0, eng_ready = 1'b0;
    logic        run_en, dma_go, srst_req, cad_rst, seq_err;
    logic [3:0]  tag_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int ms = M_IDLE, cnt = 0, dly = 0;
    logic [3:0] mtag = '0;
    bit merr = 0, mcad = 0;

    always #2.5 clk = ~clk;

    stream_ctl_reg i_stream_ctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .is_output(is_output), .stream_sync(stream_sync), .eng_stopped(eng_stopped),
        .rst_done(rst_done), .eng_ready(eng_ready), .run_en(run_en), .dma_go(dma_go),
        .srst_req(srst_req), .cad_rst(cad_rst), .tag_out(tag_out), .seq_err(seq_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        bit inr = (ms == M_ENT) || (ms == M_HOLD) || (ms == M_EXIT);
        w[23:20] = inr ? 4'h0 : mtag;
        w[1]     = (ms == M_RUN) || (ms == M_STOP);
        w[0]     = (ms == M_HOLD) || (ms == M_EXIT);
        return w;
    endfunction

    // One cycle: drive at falling edge, update model at rising edge, check 1 ns later
    task automatic step(bit we, logic [31:0] d, bit outp, bit sync);
        int ns;
        bit inr;
        @(negedge clk);
        wr_en = we; wr_data = d; is_output = outp; stream_sync = sync;
        eng_stopped = (ms == M_STOP) && (cnt >= dly);
        rst_done    = (ms == M_ENT)  && (cnt >= dly);
        eng_ready   = (ms == M_EXIT) && (cnt >= dly);
        @(posedge clk);
        ns = ms; mcad = 0;
        case (ms)
            M_IDLE: if (we) begin
                if (d[0]) begin ns = M_ENT; mtag = 0; end
                else begin
                    mtag = d[23:20];
                    if (d[1]) begin ns = M_RUN; mcad = outp; end
                end
            end
            M_RUN: if (we) begin
                mtag = d[23:20];
                if (d[0]) merr = 1;
                if (!d[1]) ns = M_STOP;
            end
            M_STOP: begin
                if (we) begin mtag = d[23:20]; if (d[0]) merr = 1; end
                if (eng_stopped) ns = M_IDLE;
            end
            M_ENT:  if (rst_done) ns = M_HOLD;
            M_HOLD: if (we && !d[0]) ns = M_EXIT;
            M_EXIT: if (eng_ready) ns = M_IDLE;
            default: ;
        endcase
        if (ns != ms) begin cnt = 0; dly = $urandom % 4; end else cnt++;
        ms = ns;
        #1;
        inr = (ms == M_ENT) || (ms == M_HOLD) || (ms == M_EXIT);
        chk("R1 reserved bits", {rd_data[31:24], rd_data[19:2]}, '0);
        chk(inr ? "R9 tag readback in reset" : "R2 tag readback", rd_data[23:20], exp_word() >> 20);
        chk("R2 tag_out", tag_out, inr ? 4'h0 : mtag);
        chk("R5 run bit readback", rd_data[1], exp_word() >> 1 & 1);
        chk("R6 R7 reset bit readback", rd_data[0], exp_word() & 1);
        chk("R3 run_en", run_en, ms == M_RUN);
        chk("R3 dma_go", dma_go, (ms == M_RUN) && !sync);
        chk("R6 srst_req", srst_req, (ms == M_ENT) || (ms == M_HOLD));
        chk("R4 cad_rst", cad_rst, mcad);
        chk("R8 seq_err", seq_err, merr);
    endtask

    function automatic logic [31:0] wd(logic [3:0] t, bit r, bit s);
        return {8'hFF, t, 18'h3FFFF, r, s}; // reserved bits set on purpose (R1)
    endfunction

    task automatic wait_state(int target);
        for (int i = 0; i < 20 && ms != target; i++) step(0, '0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11 rd_data", rd_data, '0);
        chk("R11 outputs", {run_en, dma_go, srst_req, cad_rst, seq_err, tag_out}, '0);

        // R2 R4: start output stream, reserved bits written
        step(1, wd(4'hA, 1, 0), 1, 0);
        step(0, '0, 1, 1);                       // R3 sync blocks go
        step(1, wd(4'h5, 0, 0), 1, 0);           // HALT (R5)
        // R10: restart attempt while stopping
        if (ms == M_STOP) begin
            step(1, wd(4'h7, 1, 0), 0, 0);
            chk("R10 no restart during stop", run_en, 1'b0);
        end
        wait_state(M_IDLE);
        // input stream start: no cadence pulse (R4)
        step(1, wd(4'h3, 1, 0), 0, 0);
        // R8 reset while running
        step(1, wd(4'h3, 1, 1), 0, 0);
        chk("R8 no reset entry while running", srst_req, 1'b0);
        step(1, wd(4'h3, 0, 0), 0, 0);
        wait_state(M_IDLE);
        // R6 reset with run bit set: run ignored
        step(1, wd(4'hC, 1, 1), 1, 0);
        step(1, wd(4'hF, 1, 1), 1, 0);           // R9 discarded
        wait_state(M_HOLD);
        step(1, wd(4'hE, 1, 1), 1, 0);           // R9 tag/run discarded in hold
        step(1, wd(4'h9, 1, 0), 1, 0);           // RELEASE (R7)
        wait_state(M_IDLE);
        chk("R9 tag cleared after reset", tag_out, 4'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d = $urandom;
            bit we = ($urandom % 3) == 0;
            if (($urandom % 4) != 0) d[0] = 1'b0;
            step(we, d, $urandom % 2, ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule